// File: doc/BRIEF.md
# Dual Down-Counting Timer

This peripheral holds two independent down-counters behind a small register bus. Each counter has a value register that always reads back the live count and a reload register. Software picks, for each counter, one-shot or periodic operation and one of two count sources:

- a reference tick pulse from outside the block;
- the system clock, divided by a power of two that a 3-bit exponent field sets.

A counter that reaches its terminal point latches an event bit in a shared status register. The matching interrupt line follows that bit until software clears it.

Both counters share one control word. Events are acknowledged by writing a mask in which the bits to clear are zero and every other bit is one. In periodic mode a counter loaded with N-1 in both its reload and value registers raises an event every N ticks, because it steps from zero back to the reload value. The bitwise complement of a value read gives an up-counting timebase.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset every register reads zero, both counters are stopped and both interrupt lines are low.
- R2: The control word at byte offset 0x00 holds these fields; every other bit reads as 0, so writing all ones reads back 0x01F8180F:
  - counter 0: enable bit 0, auto-reload bit 1, reference-source bit 11, prescale exponent bits 21:19;
  - counter 1: enable bit 2, auto-reload bit 3, reference-source bit 12, prescale exponent bits 24:22.
- R3: The registers at offsets 0x10 and 0x14 are counter 0's reload and value registers; those at 0x18 and 0x1C are counter 1's. All four are read/write, and a value read returns the live count.
- R4: With the reference-source bit clear and exponent d, a counter decrements once every 2^d system clocks. After a control write that changes the enable or the exponent, the prescaler restarts: the first decrement lands 2^d+1 clock edges after the write edge.
- R5: With the reference-source bit set, a counter decrements once at each clock edge where ref_tick is high, and its exponent field has no effect.
- R6: With auto-reload clear, the tick that takes the count from 1 to 0 sets the event. The count then stays at 0 with no further event.
- R7: With auto-reload set, a tick at count 0 loads the reload value and sets the event. Any other tick decrements, so reload R gives an event every R+1 ticks.
- R8: Clearing the enable bit stops counting and keeps the current count. Setting it again resumes from that count.
- R9: A bus write to a value register takes effect at that clock edge and overrides any tick due in the same cycle.
- R10: The status register at 0x04 holds counter 0's event in bit 0 and counter 1's in bit 8. A write clears each event bit written as 0 and leaves each written as 1 unchanged. A new event in the same cycle as its clear keeps the bit set.
- R11: irq[0] and irq[1] follow status bits 0 and 8 and stay high until software clears the bit.
- R12: Reads of unmapped offsets return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ref_tick | input | 1 | Reference tick, one count per high cycle |
| irq | output | 2 | Per-counter interrupt levels |

## Verification
The assertions check the following on every cycle:

- an interrupt stays high until a status write;
- an event always leaves its bit set, even against a clear;
- a value write loads the written data;
- a disabled counter holds its count;
- a finished one-shot counter rests at zero;
- a running count moves by at most one.

Only the bench scenarios can show the following:

- the exact cycle of each event for every prescale exponent;
- the reference-tick path ignoring the exponent field;
- the periodic wrap sequence;
- the register layout.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int NUM_TMR = 2;
   localparam int DIV_W   = 3;
   localparam int REG_W   = 32;

   localparam int OFF_CTRL = 'h00;
   localparam int OFF_STAT = 'h04;

   function automatic int en_pos(input int i);
      return 2 * i;
   endfunction

   function automatic int arl_pos(input int i);
      return 2 * i + 1;
   endfunction

   function automatic int src_pos(input int i);
      return 11 + i;
   endfunction

   function automatic int div_pos(input int i);
      return 19 + DIV_W * i;
   endfunction

   function automatic int stat_pos(input int i);
      return 8 * i;
   endfunction

   function automatic int rld_off(input int i);
      return 'h10 + 8 * i;
   endfunction

   function automatic int val_off(input int i);
      return 'h14 + 8 * i;
   endfunction

   function automatic logic [REG_W-1:0] ctrl_mask();
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < NUM_TMR; i++) begin
         m[en_pos(i)]  = 1'b1;
         m[arl_pos(i)] = 1'b1;
         m[src_pos(i)] = 1'b1;
         for (int b = 0; b < DIV_W; b++) m[div_pos(i) + b] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             use_ref,
   input  logic [DIV_W-1:0] div,
   input  logic             ref_tick,
   output logic             tick
);
   localparam int PS_W = (1 << DIV_W) - 1;

   if (DIV_W < 1 || DIV_W > 5) begin : g_bad_div
      $error("tmr_prescaler: DIV_W must be 1..5");
   end

   logic [PS_W-1:0] ps_cnt;
   logic [PS_W-1:0] limit;
   logic [PS_W:0]   pow;
   logic [DIV_W:0]  cfg_q;
   logic            restart;
   logic            at_lim;

   always_comb begin
      pow     = {{PS_W{1'b0}}, 1'b1} << div;
      limit   = PS_W'(pow - 1'b1);
      restart = ({run, div} != cfg_q);
      at_lim  = (ps_cnt == limit);
      tick    = run && (use_ref ? ref_tick : (!restart && at_lim));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         ps_cnt <= '0;
      end else begin
         cfg_q <= {run, div};
         if (restart || !run || use_ref || at_lim) ps_cnt <= '0;
         else                                      ps_cnt <= ps_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             auto_rl,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic [CNT_W-1:0] rld_val,
   output logic [CNT_W-1:0] cnt,
   output logic             ev
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_nx;
   logic             at_zero;

   always_comb begin
      at_zero = (cnt == '0);
      ev      = tick && !ld && (auto_rl ? at_zero : (cnt == ONE));
      cnt_nx  = cnt;
      if (ld)           cnt_nx = ld_val;
      else if (tick) begin
         if (!at_zero)     cnt_nx = cnt - ONE;
         else if (auto_rl) cnt_nx = rld_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nx;
   end
endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic              ref_tick,
   output logic [NUM_TMR-1:0] irq
);
   localparam logic [REG_W-1:0] CMASK = ctrl_mask();

   if (CNT_W < 2 || CNT_W > REG_W) begin : g_bad_cnt
      $error("dual_countdown_timer: CNT_W must be 2..32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("dual_countdown_timer: ADDR_W must be at least 5");
   end

   logic [REG_W-1:0]              ctrl_q;
   logic [NUM_TMR-1:0]            stat_q;
   logic [NUM_TMR-1:0][CNT_W-1:0] rld_q;
   logic [NUM_TMR-1:0][CNT_W-1:0] cnt;
   logic [NUM_TMR-1:0]            en, arl, src, tick, ev, wr_val, wr_rld;
   logic                          wr_ctrl, wr_stat;

   assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
   assign wr_stat = bus_we && (bus_addr == ADDR_W'(OFF_STAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= bus_wdata & CMASK;
   end

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
      assign en[i]     = ctrl_q[en_pos(i)];
      assign arl[i]    = ctrl_q[arl_pos(i)];
      assign src[i]    = ctrl_q[src_pos(i)];
      assign wr_val[i] = bus_we && (bus_addr == ADDR_W'(val_off(i)));
      assign wr_rld[i] = bus_we && (bus_addr == ADDR_W'(rld_off(i)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         rld_q[i] <= '0;
         else if (wr_rld[i]) rld_q[i] <= bus_wdata[CNT_W-1:0];
      end

      tmr_prescaler #(.DIV_W(DIV_W)) u_ps (
         .clk      (clk),
         .rst_n    (rst_n),
         .run      (en[i]),
         .use_ref  (src[i]),
         .div      (ctrl_q[div_pos(i) +: DIV_W]),
         .ref_tick (ref_tick),
         .tick     (tick[i])
      );

      tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick[i]),
         .auto_rl (arl[i]),
         .ld      (wr_val[i]),
         .ld_val  (bus_wdata[CNT_W-1:0]),
         .rld_val (rld_q[i]),
         .cnt     (cnt[i]),
         .ev      (ev[i])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stat_q[i] <= 1'b0;
         else        stat_q[i] <= (wr_stat ? (stat_q[i] & bus_wdata[stat_pos(i)])
                                           : stat_q[i]) | ev[i];
      end

      assign irq[i] = stat_q[i];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFF_CTRL)) bus_rdata = ctrl_q;
      if (bus_addr == ADDR_W'(OFF_STAT)) begin
         for (int i = 0; i < NUM_TMR; i++) bus_rdata[stat_pos(i)] = stat_q[i];
      end
      for (int i = 0; i < NUM_TMR; i++) begin
         if (bus_addr == ADDR_W'(rld_off(i))) bus_rdata = REG_W'(rld_q[i]);
         if (bus_addr == ADDR_W'(val_off(i))) bus_rdata = REG_W'(cnt[i]);
      end
   end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
   parameter int CNT_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic [1:0]          irq,
   input logic [1:0]          ev,
   input logic [1:0]          en,
   input logic [1:0]          arl,
   input logic [1:0]          wr_val,
   input logic                wr_stat,
   input logic [1:0][CNT_W-1:0] cnt,
   input logic [CNT_W-1:0]    wdata
);
   for (genvar i = 0; i < 2; i++) begin : g_chk
      p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
         irq[i] && !wr_stat |=> irq[i]);

      p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
         ev[i] |=> irq[i]);

      p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
         wr_val[i] |=> cnt[i] == $past(wdata));

      p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !en[i] && !wr_val[i] |=> $stable(cnt[i]));

      p_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
         en[i] && !arl[i] && cnt[i] == '0 && !wr_val[i] |=> cnt[i] == '0);

      p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
         en[i] && !wr_val[i] && cnt[i] != '0
         |=> (cnt[i] == $past(cnt[i])) || (cnt[i] == $past(cnt[i]) - 1'b1));
   end
endmodule

bind dual_countdown_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq     (irq),
   .ev      (ev),
   .en      (en),
   .arl     (arl),
   .wr_val  (wr_val),
   .wr_stat (wr_stat),
   .cnt     (cnt),
   .wdata   (bus_wdata[CNT_W-1:0])
);

// File: tb/dual_countdown_timer_tb.sv
module dual_countdown_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        ref_tick = 1'b0;
   logic [1:0]  irq;
   int          n_chk = 0;
   int          n_bad = 0;

   always #4 clk = ~clk;

   dual_countdown_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_rdata(rdata), .ref_tick(ref_tick), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; we = 1'b1; wdata = d;
      @(posedge clk);
      #1 we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic ref_pulse();
      @(negedge clk) ref_tick = 1'b1;
      @(negedge clk) ref_tick = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int          k;
      int          ns [4];
      ns = '{1, 2, 3, 5};
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      foreach (ns[j]) begin end
      rd(8'h00, v); check("R1 ctrl", v, 0);
      rd(8'h04, v); check("R1 stat", v, 0);
      rd(8'h10, v); check("R1 rld0", v, 0);
      rd(8'h14, v); check("R1 val0", v, 0);
      rd(8'h18, v); check("R1 rld1", v, 0);
      rd(8'h1C, v); check("R1 val1", v, 0);
      check("R1 irq", {30'd0, irq}, 0);

      // R3: register read/write
      wr(8'h10, 32'hA5A5_1234); rd(8'h10, v); check("R3 rld0", v, 32'hA5A5_1234);
      wr(8'h18, 32'h5A5A_8765); rd(8'h18, v); check("R3 rld1", v, 32'h5A5A_8765);
      wr(8'h1C, 32'hDEAD_BEEF); rd(8'h1C, v); check("R3 val1", v, 32'hDEAD_BEEF);
      wr(8'h1C, 0); wr(8'h10, 0); wr(8'h18, 0);

      // R2: control layout
      wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); check("R2 ctrl mask", v, 32'h01F8_180F);
      wr(8'h00, 0);
      wr(8'h04, 0); check("R10 clear all", {30'd0, irq}, 0);

      // R12: unmapped offsets
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h08, v); check("R12 read 08", v, 0);
      rd(8'h20, v); check("R12 read 20", v, 0);
      rd(8'h00, v); check("R12 ctrl untouched", v, 0);

      // R4/R6/R11: one-shot sweep over both counters and prescale exponents
      for (int t = 0; t < 2; t++) begin
         for (int d = 0; d < 4; d++) begin
            foreach (ns[j]) begin
               wr(8'h14 + 8'(8 * t), ns[j]);
               wr(8'h00, (32'd1 << (2 * t)) | (32'(d) << (19 + 3 * t)));
               k = 0;
               while (!irq[t] && k < 300) begin
                  @(posedge clk); #1 k++;
               end
               check("R4 event edge", k, 1 + ns[j] * (1 << d));
               repeat (3) @(posedge clk);
               #1 rd(8'h14 + 8'(8 * t), v);
               check("R6 rests at zero", v, 0);
               check("R11 irq held", {31'd0, irq[t]}, 1);
               wr(8'h00, 0);
               wr(8'h04, (t == 0) ? 32'hFFFF_FFFE : 32'hFFFF_FEFF);
               check("R10 ack", {30'd0, irq}, 0);
            end
         end
      end

      // R7: periodic wrap on counter 1, reload 3
      wr(8'h18, 3); wr(8'h1C, 3); wr(8'h00, 32'h0000_000C);
      for (int t = 1; t <= 9; t++) begin
         @(posedge clk);
         #1 rd(8'h1C, v);
         check("R7 count", v, 32'(((3 - (t - 1)) % 4 + 4) % 4));
         check("R7 irq", {31'd0, irq[1]}, (t >= 5) ? 1 : 0);
      end
      wr(8'h00, 0); wr(8'h04, 32'hFFFF_FEFF);
      check("R10 ack bit8", {30'd0, irq}, 0);

      // R10: set wins over clear, write-one leaves bit, layout
      wr(8'h10, 0); wr(8'h14, 0); wr(8'h00, 32'h3);
      repeat (4) @(posedge clk);
      wr(8'h04, 32'hFFFF_FFFE);
      check("R10 set wins", {31'd0, irq[0]}, 1);
      wr(8'h00, 0);
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, v); check("R10 ones keep", v, 32'h1);
      wr(8'h04, 32'hFFFF_FEFF);
      rd(8'h04, v); check("R10 other bit", v, 32'h1);
      wr(8'h04, 32'hFFFF_FFFE);
      rd(8'h04, v); check("R10 cleared", v, 0);

      // R5: reference source, exponent field ignored
      wr(8'h14, 3); wr(8'h00, 32'h1 | (32'h1 << 11) | (32'h3 << 19));
      ref_pulse(); ref_pulse();
      rd(8'h14, v); check("R5 two ticks", v, 1);
      repeat (10) @(posedge clk);
      #1 rd(8'h14, v); check("R5 no ref no count", v, 1);
      ref_pulse();
      rd(8'h14, v); check("R5 last tick", v, 0);
      check("R5 event", {31'd0, irq[0]}, 1);
      wr(8'h00, 0); wr(8'h04, 32'hFFFF_FFFE);

      // R8: halt keeps value, resume continues
      wr(8'h14, 100); wr(8'h00, 32'h1);
      repeat (10) @(posedge clk);
      #1 wr(8'h00, 0);
      rd(8'h14, v); check("R8 halted", v, 90);
      repeat (20) @(posedge clk);
      #1 rd(8'h14, v); check("R8 held", v, 90);
      wr(8'h00, 32'h1);
      repeat (5) @(posedge clk);
      #1 rd(8'h14, v); check("R8 resumed", v, 86);

      // R9: value write overrides a due decrement
      wr(8'h14, 50);
      rd(8'h14, v); check("R9 load", v, 50);
      @(posedge clk);
      #1 rd(8'h14, v); check("R9 next", v, 49);
      wr(8'h00, 0);
      check("R11 idle low", {30'd0, irq}, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule